// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Transmitter

This block is the transmit half of a synchronous serial port working as a slave. It does not generate a shift clock. A remote master drives a clock line into the block, and the block presents one data bit per clock period on its data output. The master samples each bit on the rising edge of the effective clock. The block changes the bit on the falling edge.

Software-style writes put a word into a single holding register. If the shifter is idle, the word moves into the shifter straight away. If the shifter is busy, the word waits in the holding register until the current frame ends. This gives double buffering. A ready flag shows that the holding register can take another word. Combined with an enable input, the flag produces an interrupt line that is pure combinational logic, so it can wake a sleeping system.

Frames are 8 bits, or 9 bits when an extra bit is enabled. Each of the clock input and the data output has its own polarity inversion control. The external clock passes through a two-stage synchronizer and an edge detector in the system clock domain.

Top module: `sync_slave_tx`

## Requirements
- R1: The block is active only when `port_en` and `sync_mode` are 1, `master_sel` is 0, `rx_cont_en` and `rx_single_en` are both 0, and `tx_en` is 1. While it is inactive, `tx_oe` is 0, both the shifter and the holding register are empty (`shift_empty` 1, `tx_ready` 1), and writes are ignored.
- R2: After reset, `tx_ready` is 1, `shift_empty` is 1, `tx_oe` is 0 and `tx_dout` sits at its idle level.
- R3: A write that arrives while the shifter is idle loads the shifter in the cycle after the write. `tx_ready` stays 1, `shift_empty` becomes 0, and bit 0 of the word appears on `tx_dout`.
- R4: A write that arrives while a frame is shifting is kept in the holding register, and `tx_ready` is 0 from the next cycle. A further write before the transfer replaces the pending word.
- R5: The falling effective clock edge that ends the last bit of a frame moves any pending word into the shifter and sets `tx_ready` again. If no word is pending, the shifter returns to idle.
- R6: Bits leave least significant bit first. Each falling edge of the effective clock advances the output by one bit. The change on `tx_dout` appears on the third system clock edge after the external edge. The idle data level is 1 before inversion.
- R7: When `clk_inv` is 1, the external clock is inverted before use, so rising edges on `ext_clk` become the shifting edges.
- R8: When `data_inv` is 1, `tx_dout` is the inverse of the serial value, and this includes the idle level.
- R9: When `nine_bit_en` is 1, a frame holds 9 bits. Bit 8 is the value of `ninth_bit` captured with the write. When `nine_bit_en` is 0, a frame holds 8 bits.
- R10: `shift_empty` is 1 exactly when no frame is shifting and no word is pending.
- R11: `tx_irq` is 1 exactly when `tx_ready` and `irq_en` are both 1. No clock lies in this path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select |
| master_sel | input | 1 | 1 selects internal clocking (not handled here); must be 0 |
| rx_cont_en | input | 1 | Continuous receive enable; must be 0 |
| rx_single_en | input | 1 | Single receive enable; must be 0 |
| tx_en | input | 1 | Transmit enable |
| nine_bit_en | input | 1 | Selects 9-bit frames |
| ninth_bit | input | 1 | Bit 8 value captured with each write |
| clk_inv | input | 1 | Inverts the external clock |
| data_inv | input | 1 | Inverts the data output |
| irq_en | input | 1 | Transmit interrupt enable |
| wr_en | input | 1 | Holding register write strobe |
| wr_data | input | DATA_W | Word to send |
| ext_clk | input | 1 | Shift clock from the master |
| tx_dout | output | 1 | Serial data out |
| tx_oe | output | 1 | Output enable for the data line |
| tx_ready | output | 1 | Holding register empty flag |
| shift_empty | output | 1 | No frame shifting and none pending |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The assertions assume three things about the inputs. The external clock holds each level for at least four system clock periods. `data_inv` and `clk_inv` change only while the block is idle or disabled. A write is one `wr_en` cycle. The stimulus drives the external clock with five system clocks per half period and changes polarity and frame-length settings only while `shift_empty` is 1. It toggles the enables freely, because a deactivation must clear all transmit state.

// File: rtl/sync_slave_tx.sv
module sync_slave_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              sync_mode,
  input  logic              master_sel,
  input  logic              rx_cont_en,
  input  logic              rx_single_en,
  input  logic              tx_en,
  input  logic              nine_bit_en,
  input  logic              ninth_bit,
  input  logic              clk_inv,
  input  logic              data_inv,
  input  logic              irq_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_clk,
  output logic              tx_dout,
  output logic              tx_oe,
  output logic              tx_ready,
  output logic              shift_empty,
  output logic              tx_irq
);
  localparam int FW = DATA_W + 1;
  localparam int CW = $clog2(FW + 1);

  logic          sync1, sync2, eff_q;
  logic          busy, hold_full;
  logic [FW-1:0] shreg, hold;
  logic [CW-1:0] cnt;

  wire active   = port_en & sync_mode & ~master_sel & ~rx_cont_en & ~rx_single_en & tx_en;
  wire eff      = sync2 ^ clk_inv;
  wire fall     = eff_q & ~eff;
  wire [CW-1:0] last = nine_bit_en ? CW'(FW - 1) : CW'(FW - 2);
  wire done     = busy & fall & (cnt == last);
  wire free     = ~busy | done;
  wire [FW-1:0] word = {ninth_bit, wr_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      eff_q <= 1'b0;
    end else begin
      sync1 <= ext_clk;
      sync2 <= sync1;
      eff_q <= eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      hold_full <= 1'b0;
      shreg     <= '1;
      hold      <= '0;
      cnt       <= '0;
    end else if (!active) begin
      busy      <= 1'b0;
      hold_full <= 1'b0;
      shreg     <= '1;
      cnt       <= '0;
    end else if (free) begin
      if (hold_full) begin
        shreg <= hold;
        busy  <= 1'b1;
        cnt   <= '0;
        if (wr_en) hold <= word;
        else       hold_full <= 1'b0;
      end else if (wr_en) begin
        shreg <= word;
        busy  <= 1'b1;
        cnt   <= '0;
      end else if (done) begin
        busy  <= 1'b0;
        shreg <= '1;
      end
    end else begin
      if (fall) begin
        shreg <= {1'b1, shreg[FW-1:1]};
        cnt   <= cnt + 1'b1;
      end
      if (wr_en) begin
        hold      <= word;
        hold_full <= 1'b1;
      end
    end
  end

  assign tx_dout     = (busy ? shreg[0] : 1'b1) ^ data_inv;
  assign tx_oe       = active;
  assign tx_ready    = ~hold_full;
  assign shift_empty = ~busy & ~hold_full;
  assign tx_irq      = tx_ready & irq_en;

  a_r1_inactive_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (shift_empty && tx_ready));

  a_r3_idle_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !busy && wr_en) |=> (!shift_empty || !active));

  a_r4_busy_write_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (active && busy && !fall && wr_en) |=> (!tx_ready || !active));

  a_r5_ready_rises_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && $rose(tx_ready)) |-> $past(fall));

  a_r6_data_holds_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && $past(busy) && !$past(fall) && !$past(wr_en)
     && $stable(data_inv)) |-> $stable(tx_dout));

  a_r10_empty_means_ready: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> tx_ready);
endmodule

// File: tb/sync_slave_tx_tb.sv
module sync_slave_tx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_en = 0, sync_mode = 0, master_sel = 0, rx_cont_en = 0, rx_single_en = 0;
  logic tx_en = 0, nine_bit_en = 0, ninth_bit = 0, clk_inv = 0, data_inv = 0, irq_en = 0;
  logic wr_en = 0;
  logic [7:0] wr_data = 8'h00;
  logic ext_clk = 1'b0;
  logic tx_dout, tx_oe, tx_ready, shift_empty, tx_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit cmp_on = 0;

  sync_slave_tx #(.DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
    .master_sel(master_sel), .rx_cont_en(rx_cont_en), .rx_single_en(rx_single_en),
    .tx_en(tx_en), .nine_bit_en(nine_bit_en), .ninth_bit(ninth_bit),
    .clk_inv(clk_inv), .data_inv(data_inv), .irq_en(irq_en),
    .wr_en(wr_en), .wr_data(wr_data), .ext_clk(ext_clk),
    .tx_dout(tx_dout), .tx_oe(tx_oe), .tx_ready(tx_ready),
    .shift_empty(shift_empty), .tx_irq(tx_irq));

  always #5 clk = ~clk;

  // reference model
  bit m_a, m_b, m_c;
  bit m_busy, m_pend;
  int m_pos;
  logic [8:0] m_frame, m_pfr;

  function automatic bit is_active();
    return port_en && sync_mode && !master_sel && !rx_cont_en && !rx_single_en && tx_en;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_c = 0;
      m_busy = 0; m_pend = 0; m_pos = 0; m_frame = '1; m_pfr = '0;
    end else begin
      bit fe, fin;
      int nb;
      nb = nine_bit_en ? 9 : 8;
      fe = m_c && !(m_b ^ clk_inv);
      m_c = m_b ^ clk_inv;
      m_b = m_a;
      m_a = ext_clk;
      if (!is_active()) begin
        m_busy = 0; m_pend = 0; m_pos = 0;
      end else begin
        fin = m_busy && fe && (m_pos == nb - 1);
        if (m_busy && fe && !fin) m_pos++;
        if (fin) m_busy = 0;
        if (!m_busy && m_pend) begin
          m_frame = m_pfr; m_busy = 1; m_pos = 0; m_pend = 0;
        end
        if (wr_en) begin
          if (!m_busy) begin m_frame = {ninth_bit, wr_data}; m_busy = 1; m_pos = 0; end
          else begin m_pfr = {ninth_bit, wr_data}; m_pend = 1; end
        end
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      logic e_dout, e_ready;
      e_dout  = (m_busy ? m_frame[m_pos] : 1'b1) ^ data_inv;
      e_ready = !m_pend;
      check("R6/R8/R9 dout", tx_dout, e_dout);
      check("R4/R5 ready", tx_ready, e_ready);
      check("R10 empty", shift_empty, !m_busy && !m_pend);
      check("R11 irq", tx_irq, e_ready && irq_en);
      check("R1 oe", tx_oe, is_active());
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ext_cycle();
    ext_clk = ~ext_clk; tick(5);
    ext_clk = ~ext_clk; tick(5);
  endtask

  task automatic write(input logic [7:0] d, input logic b8);
    @(negedge clk);
    wr_en = 1; wr_data = d; ninth_bit = b8;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic enable_all();
    port_en = 1; sync_mode = 1; master_sel = 0; rx_cont_en = 0; rx_single_en = 0; tx_en = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    tick(3);
    check("R2 ready after reset", tx_ready, 1'b1);
    check("R2 empty after reset", shift_empty, 1'b1);
    check("R2 oe after reset", tx_oe, 1'b0);
    check("R2 idle dout", tx_dout, 1'b1);
    rst_n = 1;
    tick(2);
    cmp_on = 1;

    // R3/R4/R5/R6: 8-bit, back-to-back words
    enable_all();
    tick(2);
    write(8'hA5, 1'b0);
    check("R3 ready stays high", tx_ready, 1'b1);
    check("R3 not empty", shift_empty, 1'b0);
    check("R3 bit0 on line", tx_dout, 1'b1);
    write(8'h3C, 1'b0);
    check("R4 ready low while pending", tx_ready, 1'b0);
    write(8'h5A, 1'b0);
    check("R4 still pending", tx_ready, 1'b0);
    repeat (7) ext_cycle();
    check("R5 no transfer before last edge", tx_ready, 1'b0);
    ext_cycle();
    check("R5 ready after transfer", tx_ready, 1'b1);
    check("R4 replaced word bit0", tx_dout, 1'b0);
    repeat (8) ext_cycle();
    check("R10 empty after drain", shift_empty, 1'b1);

    // R6 sync latency: falling edge shifts after 3 system edges
    write(8'h02, 1'b0);
    ext_clk = ~ext_clk;
    tick(5);
    check("R6 bit0 held", tx_dout, 1'b0);
    ext_clk = ~ext_clk;
    tick(2);
    check("R6 not yet shifted", tx_dout, 1'b0);
    tick(1);
    check("R6 shifted on third edge", tx_dout, 1'b1);
    tick(2);
    repeat (7) ext_cycle();

    // R7/R8/R9: inverted clock, inverted data, 9-bit frames, irq
    tick(4);
    clk_inv = 1; data_inv = 1; nine_bit_en = 1; irq_en = 1;
    tick(4);
    check("R8 inverted idle", tx_dout, 1'b0);
    check("R11 irq when ready", tx_irq, 1'b1);
    write(8'hFF, 1'b0);
    write(8'h81, 1'b1);
    check("R11 irq low while pending", tx_irq, 1'b0);
    repeat (8) ext_cycle();
    check("R9 ninth bit inverted", tx_dout, 1'b1);
    ext_cycle();
    check("R9 transfer after 9 edges", tx_ready, 1'b1);
    repeat (9) ext_cycle();
    check("R7 done with inverted clock", shift_empty, 1'b1);
    tick(4);
    clk_inv = 0; data_inv = 0; nine_bit_en = 0;
    tick(4);

    // R1: each blocking condition
    write(8'hF0, 1'b0);
    ext_cycle();
    rx_cont_en = 1;
    tick(2);
    check("R1 receive enable clears state", shift_empty, 1'b1);
    check("R1 oe low", tx_oe, 1'b0);
    write(8'h11, 1'b0);
    check("R1 write ignored", shift_empty, 1'b1);
    rx_cont_en = 0; rx_single_en = 1; tick(2);
    check("R1 single receive blocks", tx_oe, 1'b0);
    rx_single_en = 0; master_sel = 1; tick(2);
    check("R1 master select blocks", tx_oe, 1'b0);
    master_sel = 0; tx_en = 0;
    write(8'h22, 1'b0);
    check("R1 disabled write ignored", tx_ready, 1'b1);
    tx_en = 1; tick(2);
    check("R1 re-enabled idle", shift_empty, 1'b1);
    write(8'h96, 1'b0);
    repeat (9) ext_cycle();
    tick(5);
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule